// File: doc/BRIEF.md
# Display Panel Power-Up Sequencer

This block brings a small TFT panel controller from power-on to display-on with no processor involved. When the system reset is released it drives an active-low reset pin low and then high, then plays a fixed script of command and parameter bytes into a downstream byte port. The port carries a byte, a flag telling command from data, and a valid/ready handshake. Where the panel needs time to settle, the script holds the port idle for a set number of milliseconds. A downstream serializer turns the bytes into the physical link.

The millisecond base is taken from the `CLK_HZ` parameter. After the last step the block raises `initDone` and stays there. A `start` pulse given after that point replays the whole power-up, reset pulse included. A `start` given while a run is in progress has no effect.

Top module: `panel_boot_seq`

## Requirements
- R1: After reset and after every retrigger, `panelRstN` is low for at least `RST_LOW_MS` ms, then high for at least `RST_HIGH_MS` ms, before the first byte is offered. Directly after the system reset, `panelRstN`, `byteValid` and `initDone` are all 0.
- R2: Each run offers exactly this byte order, where F=0 marks a command and F=1 marks a parameter: C1(F=0) FF 83 40; 11(F=0); CA(F=0) 70 00 D9; B0(F=0) 01 11; C9(F=0) 90 49 10 28 28 10 00 06; B5(F=0) 35 20 45; B4(F=0) 33 25 4C; 3A(F=0) 05; 29(F=0). Every byte after a command byte and before the next command byte carries F=1. The 3A parameter 05 selects 16 bits per pixel.
- R3: While `byteValid` is 1 and `byteReady` is 0, `byteValid`, `byteData` and `byteIsData` hold their values. A byte counts as consumed only in a cycle where both `byteValid` and `byteReady` are 1.
- R4: After the sleep-exit command 11 is consumed, the next byte is offered no sooner than 150 ms later.
- R5: After the last C9 parameter is consumed, the next byte is offered no sooner than 20 ms later.
- R6: After the last B4 parameter is consumed, the next byte is offered no sooner than 10 ms later.
- R7: `initDone` rises no sooner than 10 ms after the display-on command 29 is consumed. It is 0 throughout a run and stays 1 until a retrigger.
- R8: One millisecond lasts round(`CLK_HZ`/1000) clock cycles. Every wait of N ms ends within a few cycles after N such ticks.
- R9: A `start` pulse while `initDone` is 1 clears `initDone`, pulls `panelRstN` low and replays the full sequence.
- R10: A `start` pulse during a run has no effect. The reset pin does not fall again, and the byte order and timing carry on unchanged.
- R11: `byteValid` is never 1 while `panelRstN` is low or while `initDone` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at `CLK_HZ` |
| rstN | input | 1 | Synchronous active-low system reset; its release starts a run |
| start | input | 1 | Retrigger request, honoured only after completion |
| byteReady | input | 1 | Downstream accepts the offered byte |
| byteValid | output | 1 | A byte is offered |
| byteData | output | 8 | Command or parameter byte |
| byteIsData | output | 1 | 0 = command byte, 1 = parameter byte |
| panelRstN | output | 1 | Active-low reset to the panel controller |
| initDone | output | 1 | Power-up script complete |

## Verification
The bench throttles `byteReady` in a repeating pattern. A sequencer that advanced without a real handshake would drop or repeat bytes, and one that let its outputs change under backpressure would corrupt them; both show up as scoreboard mismatches. Every wait is timed from the consuming handshake to the next offer, inside a narrow window. This catches a wait that is missing, one placed after the wrong byte, and a millisecond prescaler that is off by one cycle per tick. The reset-pin low and high phases are timed the same way. A `start` is pulsed during the 150 ms wait, which exposes a design that restarts mid-run. A second `start` after completion must reproduce the full run, reset pulse included.

// File: rtl/panel_boot_pkg.sv
package panel_boot_pkg;

  typedef enum logic [1:0] {K_CMD, K_DAT, K_WAIT, K_END} itemKind_t;

  typedef struct packed {
    itemKind_t  kind;
    logic [7:0] val;   // byte to send, or wait length in ms
  } scriptItem_t;

  typedef enum logic [1:0] {TSEL_LOW, TSEL_HIGH, TSEL_ITEM} tmrSel_t;

  typedef struct packed {
    logic    idxClr;
    logic    idxInc;
    logic    tmrLoad;
    tmrSel_t tmrSel;
  } ctrlStrobe_t;

  localparam int SCRIPT_LEN = 37;
  localparam int IDX_W      = $clog2(SCRIPT_LEN);

  function automatic scriptItem_t scriptAt(input logic [IDX_W-1:0] i);
    scriptItem_t r;
    case (i)
      6'd0:  r = '{K_CMD,  8'hC1};
      6'd1:  r = '{K_DAT,  8'hFF};
      6'd2:  r = '{K_DAT,  8'h83};
      6'd3:  r = '{K_DAT,  8'h40};
      6'd4:  r = '{K_CMD,  8'h11};
      6'd5:  r = '{K_WAIT, 8'd150};
      6'd6:  r = '{K_CMD,  8'hCA};
      6'd7:  r = '{K_DAT,  8'h70};
      6'd8:  r = '{K_DAT,  8'h00};
      6'd9:  r = '{K_DAT,  8'hD9};
      6'd10: r = '{K_CMD,  8'hB0};
      6'd11: r = '{K_DAT,  8'h01};
      6'd12: r = '{K_DAT,  8'h11};
      6'd13: r = '{K_CMD,  8'hC9};
      6'd14: r = '{K_DAT,  8'h90};
      6'd15: r = '{K_DAT,  8'h49};
      6'd16: r = '{K_DAT,  8'h10};
      6'd17: r = '{K_DAT,  8'h28};
      6'd18: r = '{K_DAT,  8'h28};
      6'd19: r = '{K_DAT,  8'h10};
      6'd20: r = '{K_DAT,  8'h00};
      6'd21: r = '{K_DAT,  8'h06};
      6'd22: r = '{K_WAIT, 8'd20};
      6'd23: r = '{K_CMD,  8'hB5};
      6'd24: r = '{K_DAT,  8'h35};
      6'd25: r = '{K_DAT,  8'h20};
      6'd26: r = '{K_DAT,  8'h45};
      6'd27: r = '{K_CMD,  8'hB4};
      6'd28: r = '{K_DAT,  8'h33};
      6'd29: r = '{K_DAT,  8'h25};
      6'd30: r = '{K_DAT,  8'h4C};
      6'd31: r = '{K_WAIT, 8'd10};
      6'd32: r = '{K_CMD,  8'h3A};
      6'd33: r = '{K_DAT,  8'h05};
      6'd34: r = '{K_CMD,  8'h29};
      6'd35: r = '{K_WAIT, 8'd10};
      default: r = '{K_END, 8'h00};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/panel_boot_dp.sv
module panel_boot_dp
  import panel_boot_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int MS_W        = 8,
  parameter int RST_LOW_MS  = 10,
  parameter int RST_HIGH_MS = 120
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output scriptItem_t item,
  output logic        tmrZero
);
  localparam int TICK_DIV = (CLK_HZ + 500) / 1000;
  localparam int PRE_W    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [IDX_W-1:0] idx;
  logic [PRE_W-1:0] pre;
  logic [MS_W-1:0]  msCnt;
  logic [MS_W-1:0]  loadVal;

  assign item    = scriptAt(idx);
  assign tmrZero = (msCnt == '0);

  always_comb begin
    case (strobe.tmrSel)
      TSEL_LOW:  loadVal = MS_W'(RST_LOW_MS);
      TSEL_HIGH: loadVal = MS_W'(RST_HIGH_MS);
      default:   loadVal = MS_W'(item.val);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx <= '0;
    end else if (strobe.idxClr) begin
      idx <= '0;
    end else if (strobe.idxInc && idx != IDX_W'(SCRIPT_LEN - 1)) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pre   <= '0;
      msCnt <= '0;
    end else if (strobe.tmrLoad) begin
      pre   <= '0;
      msCnt <= loadVal;
    end else if (msCnt != '0) begin
      if (pre == PRE_LAST) begin
        pre   <= '0;
        msCnt <= msCnt - 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assert_presc_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    pre <= PRE_LAST);
  assert_tick_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tmrLoad && msCnt != '0 && pre != PRE_LAST) |=> $stable(msCnt));
  assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    idx < IDX_W'(SCRIPT_LEN));

endmodule

// File: rtl/panel_boot_ctrl.sv
module panel_boot_ctrl
  import panel_boot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        byteReady,
  input  scriptItem_t item,
  input  logic        tmrZero,
  output ctrlStrobe_t strobe,
  output logic        byteValid,
  output logic        byteIsData,
  output logic        panelRstN,
  output logic        initDone
);
  typedef enum logic [2:0] {S_ARM, S_RLO, S_RHI, S_RUN, S_DLY, S_DONE} state_t;
  state_t state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '{idxClr: 1'b0, idxInc: 1'b0, tmrLoad: 1'b0, tmrSel: TSEL_LOW};
    case (state)
      S_ARM: begin
        strobe.idxClr  = 1'b1;
        strobe.tmrLoad = 1'b1;
        strobe.tmrSel  = TSEL_LOW;
        nextState      = S_RLO;
      end
      S_RLO: if (tmrZero) begin
        strobe.tmrLoad = 1'b1;
        strobe.tmrSel  = TSEL_HIGH;
        nextState      = S_RHI;
      end
      S_RHI: if (tmrZero) nextState = S_RUN;
      S_RUN: begin
        case (item.kind)
          K_CMD, K_DAT: strobe.idxInc = byteReady;
          K_WAIT: begin
            strobe.tmrLoad = 1'b1;
            strobe.tmrSel  = TSEL_ITEM;
            strobe.idxInc  = 1'b1;
            nextState      = S_DLY;
          end
          default: nextState = S_DONE;
        endcase
      end
      S_DLY: if (tmrZero) nextState = S_RUN;
      S_DONE: if (start) nextState = S_ARM;
      default: nextState = S_ARM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_ARM;
    else       state <= nextState;
  end

  assign byteValid  = (state == S_RUN) && (item.kind == K_CMD || item.kind == K_DAT);
  assign byteIsData = (item.kind == K_DAT);
  assign panelRstN  = !(state == S_ARM || state == S_RLO);
  assign initDone   = (state == S_DONE);

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_DONE) |=> (state != S_ARM));
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && !start) |=> initDone);
  assert_retrigger_R9: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && start) |=> (!initDone && !panelRstN));

endmodule

// File: rtl/panel_boot_seq.sv
module panel_boot_seq
  import panel_boot_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int MS_W        = 8,
  parameter int RST_LOW_MS  = 10,
  parameter int RST_HIGH_MS = 120
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       byteReady,
  output logic       byteValid,
  output logic [7:0] byteData,
  output logic       byteIsData,
  output logic       panelRstN,
  output logic       initDone
);
  ctrlStrobe_t strobe;
  scriptItem_t item;
  logic        tmrZero;

  panel_boot_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .byteReady(byteReady),
    .item(item), .tmrZero(tmrZero), .strobe(strobe),
    .byteValid(byteValid), .byteIsData(byteIsData),
    .panelRstN(panelRstN), .initDone(initDone)
  );

  panel_boot_dp #(
    .CLK_HZ(CLK_HZ), .MS_W(MS_W),
    .RST_LOW_MS(RST_LOW_MS), .RST_HIGH_MS(RST_HIGH_MS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .item(item), .tmrZero(tmrZero)
  );

  assign byteData = item.val;

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !byteReady) |=> (byteValid && $stable(byteData) && $stable(byteIsData)));
  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!panelRstN || initDone) |-> !byteValid);

endmodule

// File: tb/panel_boot_seq_tb_top.sv
module panel_boot_seq_tb_top;
  localparam int CLK_HZ = 100_000;
  localparam int TICK   = 100;
  localparam int NBYTES = 32;

  logic clk = 0, rstN = 0, start = 0, byteReady = 0;
  logic byteValid, byteIsData, panelRstN, initDone;
  logic [7:0] byteData;

  panel_boot_seq #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .byteReady(byteReady),
    .byteValid(byteValid), .byteData(byteData), .byteIsData(byteIsData),
    .panelRstN(panelRstN), .initDone(initDone)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  logic [8:0] expQ[$];
  int runIdx = 0, hsCyc = 0, gapNeed = 0, lowCnt = 0, hiStart = 0, rstFalls = 0, quietViol = 0;
  logic prevValid = 0, prevReady = 0, prevRst = 0, prevDone = 0, prevIsData = 0;
  logic [7:0] prevData = 0;
  bit summaryDone = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h), expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic inWin(input string req, input int act, input int lo);
    chk(act >= lo && act <= lo + 6, req, act, lo);
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // driver: expected script, one entry {isData, byte}
  task automatic pushC(input logic [7:0] b); expQ.push_back({1'b0, b}); endtask
  task automatic pushD(input logic [7:0] b); expQ.push_back({1'b1, b}); endtask
  task automatic pushScript();
    pushC(8'hC1); pushD(8'hFF); pushD(8'h83); pushD(8'h40);
    pushC(8'h11);
    pushC(8'hCA); pushD(8'h70); pushD(8'h00); pushD(8'hD9);
    pushC(8'hB0); pushD(8'h01); pushD(8'h11);
    pushC(8'hC9); pushD(8'h90); pushD(8'h49); pushD(8'h10); pushD(8'h28);
    pushD(8'h28); pushD(8'h10); pushD(8'h00); pushD(8'h06);
    pushC(8'hB5); pushD(8'h35); pushD(8'h20); pushD(8'h45);
    pushC(8'hB4); pushD(8'h33); pushD(8'h25); pushD(8'h4C);
    pushC(8'h3A); pushD(8'h05);
    pushC(8'h29);
  endtask

  // ready throttling
  initial forever begin
    @(posedge clk); #1;
    byteReady = (cyc % 3) != 2;
  end

  // monitor / scoreboard
  always @(negedge clk) if (rstN) begin
    if (byteValid && (!panelRstN || initDone)) quietViol++;
    if (prevRst && !panelRstN) begin
      rstFalls++; lowCnt = 0; runIdx = 0;
    end
    if (!panelRstN) lowCnt++;
    if (!prevRst && panelRstN) begin
      inWin("R1 reset low cycles", lowCnt, 10 * TICK);
      hiStart = cyc;
    end
    if (prevValid && !prevReady)
      chk(byteValid && byteData == prevData && byteIsData == prevIsData,
          "R3 hold under backpressure", {byteIsData, byteData}, {prevIsData, prevData});
    if (byteValid && !prevValid) begin
      if (runIdx == 0) inWin("R1 reset high before first byte", cyc - hiStart, 120 * TICK);
      else if (gapNeed == 150) inWin("R4 wait after sleep exit", cyc - hsCyc, 150 * TICK);
      else if (gapNeed == 20) inWin("R5 wait after drive setting", cyc - hsCyc, 20 * TICK);
      else if (gapNeed == 10) inWin("R6 wait after power control", cyc - hsCyc, 10 * TICK);
    end
    if (byteValid && byteReady) begin
      if (expQ.size() == 0) chk(0, "R2 unexpected byte", {byteIsData, byteData}, 0);
      else begin
        logic [8:0] e;
        e = expQ.pop_front();
        chk({byteIsData, byteData} == e, "R2 byte and flag", {byteIsData, byteData}, e);
      end
      hsCyc = cyc;
      gapNeed = (runIdx == 4) ? 150 : (runIdx == 20) ? 20 : (runIdx == 28) ? 10 : 0;
      runIdx++;
    end
    if (initDone && !prevDone) begin
      inWin("R7 final wait before done", cyc - hsCyc, 10 * TICK);
      chk(runIdx == NBYTES, "R7 bytes before done", runIdx, NBYTES);
    end
    prevValid = byteValid; prevReady = byteReady; prevData = byteData;
    prevIsData = byteIsData; prevRst = panelRstN; prevDone = initDone;
  end

  task automatic pulseStart();
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(panelRstN == 0 && byteValid == 0 && initDone == 0, "R1 reset state",
        {panelRstN, byteValid, initDone}, 0);
    pushScript();
    @(posedge clk); #1 rstN = 1;
    wait (runIdx >= 5);
    pulseStart();   // R10: must be ignored during the 150 ms wait
    wait (initDone);
    @(negedge clk);
    chk(rstFalls == 0, "R10 no restart on mid-run start", rstFalls, 0);
    chk(expQ.size() == 0, "R10 full sequence completed", expQ.size(), 0);
    repeat (50) @(negedge clk);
    chk(initDone == 1, "R7 done held", initDone, 1);
    pushScript();
    pulseStart();   // R9 retrigger
    @(negedge clk);
    chk(initDone == 0 && panelRstN == 0, "R9 retrigger clears done and pulls reset",
        {initDone, panelRstN}, 0);
    wait (initDone);
    @(negedge clk);
    chk(rstFalls == 1, "R9 one reset pulse on retrigger", rstFalls, 1);
    chk(expQ.size() == 0, "R9 replayed sequence complete", expQ.size(), 0);
    chk(quietViol == 0, "R11 no byte while reset low or done", quietViol, 0);
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    finishRun();
  end

endmodule